// File: doc/BRIEF.md
# Quadword Load Register-Pair Sequencer

This block carries out a 16-byte load whose result lands in two neighbouring general registers: an even-numbered target and the odd register just above it. It takes the target index, a byte address and a byte-order mode bit. It then fetches the two doublewords of the quadword one after the other over a memory read port with a valid/ready request channel and a response strobe. It hands each returned doubleword to a single register write port, one write per cycle.

The byte-order mode decides both where each doubleword goes and whether its bytes are reversed. In big-endian mode, the lower-addressed doubleword goes unchanged to the even register and the upper one to the odd register. In little-endian mode, each doubleword is byte-reversed and the pairing is crossed: the upper doubleword goes to the even register and the lower one to the odd register. A request that names an odd target is rejected with a one-cycle error pulse and touches nothing.

Top module: `qpair_load_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1 and `rd_valid`, `wr_en`, `done` and `err` are 0.
- R2: A request accepted with `req_tgt[0]` = 1 raises `err` for exactly one cycle, in the cycle after acceptance. It issues no memory read, makes no register write and leaves `req_ready` at 1.
- R3: An even-target request issues exactly two reads. The first is at the request address with its low 4 bits cleared. The second is at that address plus 8 and is issued only after the first response. `rd_valid` and `rd_addr` hold steady until `rd_ready` is seen.
- R4: With `req_le` = 0, the doubleword from the lower address is written unchanged to register `req_tgt`. The doubleword from the upper address is written to register `req_tgt`+1.
- R5: With `req_le` = 1, each doubleword is byte-reversed before it is written: byte k of `wr_data` (bits 8k+7..8k) is byte 7-k of `rsp_data`. The lower-address doubleword goes to `req_tgt`+1 and the upper-address doubleword goes to `req_tgt`.
- R6: Each accepted response produces exactly one register write, with `wr_en` high in the cycle after the response. Two writes are never in adjacent cycles.
- R7: `done` is a one-cycle pulse in the cycle right after the second write. `req_ready` is 0 from acceptance until that cycle and is 1 in it.
- R8: A `rsp_valid` pulse while the block is not waiting for a response causes no register write.
- R9: A `req_valid` while the block is busy is ignored: no error, and the running load completes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request strobe, taken when `req_ready` is 1 |
| req_ready | output | 1 | Block is idle and can take a request |
| req_tgt | input | RIW | Target register index, must be even |
| req_addr | input | AW | Byte address of the quadword |
| req_le | input | 1 | 1 selects little-endian steering and byte reversal |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | AW | Byte address of the doubleword read |
| rsp_valid | input | 1 | Read data is present |
| rsp_data | input | DW | Returned doubleword |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | RIW | Register being written |
| wr_data | output | DW | Data being written |
| done | output | 1 | Load finished, both registers written |
| err | output | 1 | Request rejected for an odd target |

## Verification
The bench sweeps every target index, both byte orders and several addresses, including ones with nonzero low bits. This separates correct alignment from simple address pass-through, and crossed pairing from straight pairing. Memory data has a distinct value in every byte lane, so a missing, partial or wrong-direction reversal shows up as a miscompare. The memory side varies its `rd_ready` stalls and response latency, which tests that reads are held and ordered and that write and done timing follows the responses. Stray responses while idle and stray requests while busy test that the block ignores them.

// File: rtl/qpl_pkg.sv
package qpl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASK_LO,
    ST_WAIT_LO,
    ST_ASK_HI,
    ST_WAIT_HI,
    ST_FINISH
  } qpl_state_e;
endpackage

// File: rtl/qpl_ctrl.sv
module qpl_ctrl
  import qpl_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 64,
  parameter int RIW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [RIW-1:0] req_tgt,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_le,
  output logic           req_ready,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [AW-1:0]  rd_addr,
  input  logic           rsp_valid,
  output logic           cap,
  output logic           cap_hi,
  output logic [RIW-1:0] tgt_q,
  output logic           le_q,
  output logic           done,
  output logic           err
);
  localparam int DBYTES = DW / 8;
  localparam int QOFS   = $clog2(2 * DBYTES);
  localparam int HBIT   = QOFS - 1;

  qpl_state_e st;

  assign req_ready = (st == ST_IDLE);
  assign cap       = rsp_valid && ((st == ST_WAIT_LO) || (st == ST_WAIT_HI));
  assign cap_hi    = (st == ST_WAIT_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      rd_valid <= 1'b0;
      rd_addr  <= '0;
      tgt_q    <= '0;
      le_q     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_tgt[0]) begin
              err <= 1'b1;
            end else begin
              st       <= ST_ASK_LO;
              rd_valid <= 1'b1;
              rd_addr  <= {req_addr[AW-1:QOFS], {QOFS{1'b0}}};
              tgt_q    <= req_tgt;
              le_q     <= req_le;
            end
          end
        end
        ST_ASK_LO: begin
          if (rd_ready) begin
            rd_valid <= 1'b0;
            st       <= ST_WAIT_LO;
          end
        end
        ST_WAIT_LO: begin
          if (rsp_valid) begin
            rd_valid      <= 1'b1;
            rd_addr[HBIT] <= 1'b1;
            st            <= ST_ASK_HI;
          end
        end
        ST_ASK_HI: begin
          if (rd_ready) begin
            rd_valid <= 1'b0;
            st       <= ST_WAIT_HI;
          end
        end
        ST_WAIT_HI: begin
          if (rsp_valid) st <= ST_FINISH;
        end
        ST_FINISH: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: a pending read request holds until accepted
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R3: the upper-half read starts only after a response
  p_hi_after_rsp_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !$past(rd_valid) && rd_addr[HBIT] |-> $past(rsp_valid));

  // R2: rejection leaves the block idle with no read
  p_err_idle_r2: assert property (@(posedge clk) disable iff (rst)
    err |-> req_ready && !rd_valid);

  p_err_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: no read request while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !rd_valid);
endmodule

// File: rtl/qpl_steer.sv
module qpl_steer #(
  parameter int DW  = 64,
  parameter int RIW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cap,
  input  logic           cap_hi,
  input  logic           le,
  input  logic [RIW-1:0] tgt,
  input  logic [DW-1:0]  rsp_data,
  output logic           wr_en,
  output logic [RIW-1:0] wr_idx,
  output logic [DW-1:0]  wr_data
);
  localparam int NB = DW / 8;

  logic [DW-1:0] swapped;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign swapped[8*b +: 8] = rsp_data[8*(NB-1-b) +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= cap;
      if (cap) begin
        // the lower half lands in the even register only in big-endian mode
        wr_idx  <= {tgt[RIW-1:1], cap_hi ^ le};
        wr_data <= le ? swapped : rsp_data;
      end
    end
  end

  // R6: one write per captured response, never back to back
  p_wr_follows_cap_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(cap));

  p_wr_spaced_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
endmodule

// File: rtl/qpair_load_seq.sv
module qpair_load_seq #(
  parameter int AW  = 32,
  parameter int DW  = 64,
  parameter int RIW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [RIW-1:0] req_tgt,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_le,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [AW-1:0]  rd_addr,
  input  logic           rsp_valid,
  input  logic [DW-1:0]  rsp_data,
  output logic           wr_en,
  output logic [RIW-1:0] wr_idx,
  output logic [DW-1:0]  wr_data,
  output logic           done,
  output logic           err
);
  logic           cap;
  logic           cap_hi;
  logic [RIW-1:0] tgt_q;
  logic           le_q;

  qpl_ctrl #(.AW(AW), .DW(DW), .RIW(RIW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_tgt   (req_tgt),
    .req_addr  (req_addr),
    .req_le    (req_le),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .rsp_valid (rsp_valid),
    .cap       (cap),
    .cap_hi    (cap_hi),
    .tgt_q     (tgt_q),
    .le_q      (le_q),
    .done      (done),
    .err       (err)
  );

  qpl_steer #(.DW(DW), .RIW(RIW)) u_steer (
    .clk      (clk),
    .rst      (rst),
    .cap      (cap),
    .cap_hi   (cap_hi),
    .le       (le_q),
    .tgt      (tgt_q),
    .rsp_data (rsp_data),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  // R7: completion follows the second write directly
  p_done_after_wr_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(wr_en) && !wr_en);

  // R8: no write while idle without a pending capture
  p_idle_no_wr_r8: assert property (@(posedge clk) disable iff (rst)
    req_ready && !done |-> !wr_en);
endmodule

// File: tb/test_qpair_load_seq.sv
`timescale 1ns/1ps
module test_qpair_load_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_tgt = '0;
  logic [31:0] req_addr = '0;
  logic        req_le = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_addr;
  logic        rsp_valid = 1'b0;
  logic [63:0] rsp_data = '0;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data;
  logic        done;
  logic        err;

  int vectors = 0;
  int misses  = 0;
  int cyc_cnt = 0;
  int rcount  = 0;
  logic [31:0] raddr [0:3];
  bit spur_req = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  qpair_load_seq i_qpair_load_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_tgt(req_tgt), .req_addr(req_addr), .req_le(req_le),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .done(done), .err(err)
  );

  function automatic logic [63:0] memdat(input logic [31:0] a);
    logic [63:0] d;
    for (int i = 0; i < 8; i++)
      d[8*i +: 8] = a[11:4] * 8'd3 + 8'(i * 29) + a[3:0] * 8'd7 + a[31:24];
    return d;
  endfunction

  function automatic logic [63:0] brev(input logic [63:0] d);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = d[8*(7-i) +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory responder, drives at falling edges
  initial begin
    bit pend = 0;
    int dly = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      cyc_cnt++;
      rsp_valid = 1'b0;
      if (spur_req) begin
        rsp_valid = 1'b1;
        rsp_data  = 64'hDEAD_BEEF_0123_4567;
        spur_req  = 0;
      end else if (pend) begin
        if (dly == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = memdat(paddr);
          pend = 0;
        end else dly--;
      end
      rd_ready = (cyc_cnt % 3) != 1;
      if (rd_valid && rd_ready) begin
        if (rcount < 4) raddr[rcount] = rd_addr;
        rcount++;
        paddr = rd_addr;
        pend  = 1;
        dly   = (cyc_cnt / 3) % 3;
      end
    end
  end

  task automatic run(input logic [4:0] tgt, input logic [31:0] addr, input logic le);
    logic [31:0] base;
    logic [63:0] e0, e1;
    logic [4:0]  xi0, xi1;
    logic [63:0] xd0, xd1;
    logic [4:0]  wi [0:1];
    logic [63:0] wd [0:1];
    int nw = 0;
    int last_wr = -10;
    int cyc = 0;
    bit got_done = 0;
    base = {addr[31:4], 4'h0};
    e0 = memdat(base);
    e1 = memdat(base + 32'd8);
    if (!le) begin
      xi0 = tgt;     xd0 = e0;       xi1 = tgt + 5'd1; xd1 = e1;
    end else begin
      xi0 = tgt + 5'd1; xd0 = brev(e0); xi1 = tgt;     xd1 = brev(e1);
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rcount = 0;
    req_valid = 1'b1; req_tgt = tgt; req_addr = addr; req_le = le;
    @(negedge clk);
    req_valid = 1'b0;
    if (tgt[0]) begin
      chk(err === 1'b1, "R2 err pulse", 64'(err), 64'd1);
      chk(req_ready === 1'b1, "R2 stays ready", 64'(req_ready), 64'd1);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (wr_en !== 1'b0 || rd_valid !== 1'b0 || err !== 1'b0)
          chk(0, "R2 quiet after reject", {61'd0, wr_en, rd_valid, err}, 64'd0);
      end
      chk(rcount == 0, "R2 no reads", 64'(rcount), 64'd0);
    end else begin
      chk(req_ready === 1'b0, "R7 busy after accept", 64'(req_ready), 64'd0);
      while (!got_done && cyc < 80) begin
        if (cyc == 2) begin
          req_valid = 1'b1; req_tgt = 5'd3; req_addr = 32'hFFFF_FFF0;
        end else req_valid = 1'b0;
        if (err !== 1'b0) chk(0, "R9 busy request ignored", 64'(err), 64'd0);
        if (wr_en === 1'b1) begin
          if (nw < 2) begin wi[nw] = wr_idx; wd[nw] = wr_data; end
          if (cyc == last_wr + 1) chk(0, "R6 writes spaced", 64'(cyc), 64'(last_wr + 2));
          nw++;
          last_wr = cyc;
        end
        if (done === 1'b1) begin
          got_done = 1;
          chk(nw == 2, "R7 two writes before done", 64'(nw), 64'd2);
          chk(last_wr == cyc - 1, "R7 done follows write", 64'(last_wr), 64'(cyc - 1));
          chk(req_ready === 1'b1, "R7 ready with done", 64'(req_ready), 64'd1);
        end else begin
          if (req_ready !== 1'b0) chk(0, "R7 busy until done", 64'(req_ready), 64'd0);
          @(negedge clk);
          cyc++;
        end
      end
      req_valid = 1'b0;
      chk(got_done, "R7 done seen", 64'(got_done), 64'd1);
      chk(rcount == 2, "R3 read count", 64'(rcount), 64'd2);
      if (rcount >= 2) begin
        chk(raddr[0] == base, "R3 first read aligned", 64'(raddr[0]), 64'(base));
        chk(raddr[1] == base + 32'd8, "R3 second read", 64'(raddr[1]), 64'(base + 32'd8));
      end
      if (nw >= 2) begin
        if (!le) begin
          chk(wi[0] == xi0 && wd[0] == xd0, "R4 even <- low half", wd[0], xd0);
          chk(wi[1] == xi1 && wd[1] == xd1, "R4 odd <- high half", wd[1], xd1);
        end else begin
          chk(wi[0] == xi0 && wd[0] == xd0, "R5 odd <- reversed low half", wd[0], xd0);
          chk(wi[1] == xi1 && wd[1] == xd1, "R5 even <- reversed high half", wd[1], xd1);
        end
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    chk({rd_valid, wr_en, done, err} === 4'b0, "R1 outputs quiet",
        {60'd0, rd_valid, wr_en, done, err}, 64'd0);

    // R8: stray response while idle
    spur_req = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (wr_en !== 1'b0) chk(0, "R8 stray response ignored", 64'(wr_en), 64'd0);
    end
    chk(wr_en === 1'b0, "R8 no write after stray response", 64'(wr_en), 64'd0);

    for (int a = 0; a < 4; a++) begin
      for (int t = 0; t < 32; t++) begin
        for (int l = 0; l < 2; l++) begin
          logic [31:0] ad;
          ad = (a == 0) ? 32'h0000_0000 : (a == 1) ? 32'h1234_567B :
               (a == 2) ? 32'hFFFF_FFF7 : 32'h8000_0A05 + 32'(t * 16);
          run(5'(t), ad, l[0]);
        end
      end
    end

    // R8: stray response after activity
    spur_req = 1;
    repeat (3) @(negedge clk);
    chk(wr_en === 1'b0, "R8 stray after loads", 64'(wr_en), 64'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      misses++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc_cnt);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule